// File: doc/BRIEF.md
# Mirrored LCD Display Memory Controller

This block sits at the front of a small matrix LCD driver and owns the display memory. A host sends column-set commands, bank-set commands and pixel data bytes. Each data byte goes into a dual-port RAM at the current bank and column, and the cursor then moves on by one. A horizontal-mirror input reverses the column order when data is written. Data already in the RAM is not moved when that input changes, so a mirrored picture needs a fresh write.

The refresh logic reads one byte per scan request through a second, read-only port. Host writes therefore never wait for scanning. A vertical-flip bit in the mode register reverses the bank order on this read path. It takes effect on the next scan request, with no rewrite of the RAM.

The mode register also selects one of several display modes, and power-down is one of them. In power-down the drive, bias, voltage-generator and oscillator enables go low and the pixel output is forced to zero. The RAM keeps its contents and still accepts writes.

Top module: `lcd_dram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is in power-down. `drv_en`, `bias_en`, `vgen_en`, `osc_en` and `pix_valid` are 0, and `pix_out` is 0.
- R2: Each `wr_en` cycle stores `wr_data` at the current bank and column, then advances the column. After column 95 the column returns to 0 and the bank advances by one. After bank 16 the bank returns to 0.
- R3: `setx_en` with `setx_val` in 0..95 loads the column cursor. A value above 95 is ignored and the cursor keeps its value.
- R4: `sety_en` with `sety_val` in 0..16 loads the bank cursor. A value above 16 is ignored and the cursor keeps its value.
- R5: The write position depends on `mirror_x`. With `mirror_x`=0, cursor column X is stored at physical column X. With `mirror_x`=1, it is stored at physical column 95−X. Changing `mirror_x` does not change bytes already stored.
- R6: A scan request for bank B reads physical bank B when the vertical-flip bit is 0. It reads physical bank 16−B when the bit is 1. The flip bit used is the one held in the cycle of the request.
- R7: `pix_valid` is 1 exactly two clock edges after the edge that samples `scan_req`=1.
- R8: The mode register has three control bits: display-on, all-pixels-on and invert. It decodes them into the following `pix_out` values:
  - on=1, all=1: all ones.
  - on=1, all=0, invert=0: the byte read from the RAM.
  - on=1, all=0, invert=1: the bitwise inverse of the byte read.
  - on=0, all=0: zero.
- R9: Power-down holds exactly when display-on=0 and all-pixels-on=1. In power-down the four enables are 0 and `pix_out` is 0. In every other mode the four enables are 1.
- R10: Writes and cursor commands made during power-down are stored and can be read back once the display is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mirror_x | input | 1 | Horizontal mirror applied at write time |
| wr_en | input | 1 | Pixel data write strobe |
| wr_data | input | 8 | Pixel data byte |
| setx_en | input | 1 | Column-set command strobe |
| setx_val | input | 7 | Requested column |
| sety_en | input | 1 | Bank-set command strobe |
| sety_val | input | 5 | Requested bank |
| mode_en | input | 1 | Mode register load strobe |
| mode_on | input | 1 | Display-on bit |
| mode_allon | input | 1 | All-pixels-on bit |
| mode_inv | input | 1 | Invert bit |
| mode_vflip | input | 1 | Vertical-flip bit |
| scan_req | input | 1 | Refresh read request |
| scan_bank | input | 5 | Logical bank to scan |
| scan_col | input | 7 | Column to scan |
| pix_out | output | 8 | Shaped pixel byte for the column drivers |
| pix_valid | output | 1 | `pix_out` holds a scan result |
| drv_en | output | 1 | Row and column drive enable |
| bias_en | output | 1 | Bias generator enable |
| vgen_en | output | 1 | Voltage generator enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
A write or cursor command takes effect at the next edge. The bench can only observe it by a later scan, whose result appears after two more edges. The bench drives each request on a falling edge and samples `pix_out` on the falling edge after the second rising edge. The four enables are due one edge after `mode_en`. The shaped pixel uses the mode held at the edge that loads the output register. The cycle model in the bench updates in that same order and is compared on every falling edge.

// File: rtl/lcd_dram_pkg.sv
package lcd_dram_pkg;
  typedef enum logic [2:0] {
    DM_BLANK,
    DM_NORMAL,
    DM_INVERSE,
    DM_ALLON,
    DM_POWERDOWN
  } disp_mode_e;

  typedef struct packed {
    logic on;
    logic allon;
    logic inv;
    logic vflip;
  } mode_bits_t;

  function automatic disp_mode_e decode_mode(mode_bits_t m);
    if (!m.on && m.allon) return DM_POWERDOWN;
    if (!m.on) return DM_BLANK;
    if (m.allon) return DM_ALLON;
    if (m.inv) return DM_INVERSE;
    return DM_NORMAL;
  endfunction
endpackage

// File: rtl/lcd_dram_addr.sv
module lcd_dram_addr #(
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 17,
  parameter int COL_W     = $clog2(NUM_COLS),
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ADDR_W    = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mirror_x,
  input  logic              wr_en,
  input  logic              setx_en,
  input  logic [COL_W-1:0]  setx_val,
  input  logic              sety_en,
  input  logic [BANK_W-1:0] sety_val,
  output logic [COL_W-1:0]  cur_x,
  output logic [BANK_W-1:0] cur_y,
  output logic [ADDR_W-1:0] waddr
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic             setx_ok, sety_ok, col_end;
  logic [COL_W-1:0] phys_col;

  assign setx_ok = setx_en && (setx_val <= LAST_COL);
  assign sety_ok = sety_en && (sety_val <= LAST_BANK);
  assign col_end = (cur_x == LAST_COL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_x <= '0;
      cur_y <= '0;
    end else begin
      if (setx_ok)     cur_x <= setx_val;
      else if (wr_en)  cur_x <= col_end ? '0 : cur_x + 1'b1;

      if (sety_ok)               cur_y <= sety_val;
      else if (wr_en && col_end) cur_y <= (cur_y == LAST_BANK) ? '0 : cur_y + 1'b1;
    end
  end

  assign phys_col = mirror_x ? (LAST_COL - cur_x) : cur_x;
  assign waddr    = ADDR_W'(cur_y) * ADDR_W'(NUM_COLS) + ADDR_W'(phys_col);
endmodule

// File: rtl/lcd_dram_ram.sv
module lcd_dram_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1632,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/lcd_dram_mode.sv
module lcd_dram_mode
  import lcd_dram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_en,
  input  mode_bits_t mode_in,
  output mode_bits_t mode_q,
  output logic       drv_en,
  output logic       bias_en,
  output logic       vgen_en,
  output logic       osc_en
);
  logic next_live;

  assign next_live = (decode_mode(mode_in) != DM_POWERDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '{on: 1'b0, allon: 1'b1, inv: 1'b0, vflip: 1'b0};
      drv_en  <= 1'b0;
      bias_en <= 1'b0;
      vgen_en <= 1'b0;
      osc_en  <= 1'b0;
    end else if (mode_en) begin
      mode_q  <= mode_in;
      drv_en  <= next_live;
      bias_en <= next_live;
      vgen_en <= next_live;
      osc_en  <= next_live;
    end
  end
endmodule

// File: rtl/lcd_dram_scan.sv
module lcd_dram_scan
  import lcd_dram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 17,
  parameter int COL_W     = $clog2(NUM_COLS),
  parameter int BANK_W    = $clog2(NUM_BANKS),
  parameter int ADDR_W    = $clog2(NUM_COLS * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_bits_t        mode_q,
  input  logic              scan_req,
  input  logic [BANK_W-1:0] scan_bank,
  input  logic [COL_W-1:0]  scan_col,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pix_out,
  output logic              pix_valid
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] phys_bank;
  logic              rd_pend;
  logic [DATA_W-1:0] shaped;

  assign phys_bank = mode_q.vflip ? (LAST_BANK - scan_bank) : scan_bank;
  assign raddr     = ADDR_W'(phys_bank) * ADDR_W'(NUM_COLS) + ADDR_W'(scan_col);

  always_comb begin
    unique case (decode_mode(mode_q))
      DM_NORMAL:  shaped = rdata;
      DM_INVERSE: shaped = ~rdata;
      DM_ALLON:   shaped = '1;
      default:    shaped = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      pix_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      rd_pend   <= scan_req;
      pix_valid <= rd_pend;
      pix_out   <= shaped;
    end
  end
endmodule

// File: rtl/lcd_dram_ctrl.sv
module lcd_dram_ctrl
  import lcd_dram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 17,
  parameter int COL_W     = $clog2(NUM_COLS),
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mirror_x,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              setx_en,
  input  logic [COL_W-1:0]  setx_val,
  input  logic              sety_en,
  input  logic [BANK_W-1:0] sety_val,
  input  logic              mode_en,
  input  logic              mode_on,
  input  logic              mode_allon,
  input  logic              mode_inv,
  input  logic              mode_vflip,
  input  logic              scan_req,
  input  logic [BANK_W-1:0] scan_bank,
  input  logic [COL_W-1:0]  scan_col,
  output logic [DATA_W-1:0] pix_out,
  output logic              pix_valid,
  output logic              drv_en,
  output logic              bias_en,
  output logic              vgen_en,
  output logic              osc_en
);
  localparam int DEPTH  = NUM_COLS * NUM_BANKS;
  localparam int ADDR_W = $clog2(DEPTH);

  logic [COL_W-1:0]  cur_x;
  logic [BANK_W-1:0] cur_y;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;
  mode_bits_t        mode_in, mode_q;

  assign mode_in = '{on: mode_on, allon: mode_allon, inv: mode_inv, vflip: mode_vflip};

  lcd_dram_addr #(.NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS), .COL_W(COL_W),
                  .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .mirror_x(mirror_x), .wr_en(wr_en),
    .setx_en(setx_en), .setx_val(setx_val), .sety_en(sety_en), .sety_val(sety_val),
    .cur_x(cur_x), .cur_y(cur_y), .waddr(waddr)
  );

  lcd_dram_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  lcd_dram_mode u_mode (
    .clk(clk), .rst(rst), .mode_en(mode_en), .mode_in(mode_in), .mode_q(mode_q),
    .drv_en(drv_en), .bias_en(bias_en), .vgen_en(vgen_en), .osc_en(osc_en)
  );

  lcd_dram_scan #(.DATA_W(DATA_W), .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS),
                  .COL_W(COL_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst(rst), .mode_q(mode_q), .scan_req(scan_req),
    .scan_bank(scan_bank), .scan_col(scan_col), .raddr(raddr), .rdata(rdata),
    .pix_out(pix_out), .pix_valid(pix_valid)
  );
endmodule

// File: rtl/lcd_dram_chk.sv
module lcd_dram_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 96,
  parameter int NUM_BANKS = 17,
  parameter int COL_W     = $clog2(NUM_COLS),
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              setx_en,
  input logic              sety_en,
  input logic              mode_en,
  input logic              mode_on,
  input logic              mode_allon,
  input logic              scan_req,
  input logic [DATA_W-1:0] pix_out,
  input logic              pix_valid,
  input logic              drv_en,
  input logic              bias_en,
  input logic              vgen_en,
  input logic              osc_en,
  input logic [COL_W-1:0]  cur_x,
  input logic [BANK_W-1:0] cur_y
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

  AST_PD_ENABLES_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_en && !mode_on && mode_allon) |=> (!drv_en && !bias_en && !vgen_en && !osc_en)); // R9
  AST_LIVE_ENABLES_ON: assert property (@(posedge clk) disable iff (rst)
    (mode_en && (mode_on || !mode_allon)) |=> (drv_en && bias_en && vgen_en && osc_en)); // R9
  AST_PD_PIX_DARK: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !$past(drv_en)) |-> (pix_out == '0)); // R9
  AST_SCAN_LATENCY: assert property (@(posedge clk) disable iff (rst)
    scan_req |-> ##2 pix_valid); // R7
  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_x <= LAST_COL); // R3
  AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cur_y <= LAST_BANK); // R4
  AST_CURSOR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !setx_en && !sety_en && cur_x == LAST_COL && cur_y == LAST_BANK)
      |=> (cur_x == '0 && cur_y == '0)); // R2
endmodule

bind lcd_dram_ctrl lcd_dram_chk #(
  .DATA_W(DATA_W), .NUM_COLS(NUM_COLS), .NUM_BANKS(NUM_BANKS),
  .COL_W(COL_W), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .setx_en(setx_en), .sety_en(sety_en),
  .mode_en(mode_en), .mode_on(mode_on), .mode_allon(mode_allon),
  .scan_req(scan_req), .pix_out(pix_out), .pix_valid(pix_valid),
  .drv_en(drv_en), .bias_en(bias_en), .vgen_en(vgen_en), .osc_en(osc_en),
  .cur_x(cur_x), .cur_y(cur_y)
);

// File: tb/sim_lcd_dram_ctrl.sv
module sim_lcd_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 96;
  localparam int NB = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mirror_x = 0, wr_en = 0, setx_en = 0, sety_en = 0, mode_en = 0;
  logic [7:0] wr_data = 0;
  logic [6:0] setx_val = 0, scan_col = 0;
  logic [4:0] sety_val = 0, scan_bank = 0;
  logic mode_on = 0, mode_allon = 0, mode_inv = 0, mode_vflip = 0, scan_req = 0;
  logic [7:0] pix_out;
  logic pix_valid, drv_en, bias_en, vgen_en, osc_en;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_dram_ctrl u0 (
    .clk(clk), .rst(rst), .mirror_x(mirror_x), .wr_en(wr_en), .wr_data(wr_data),
    .setx_en(setx_en), .setx_val(setx_val), .sety_en(sety_en), .sety_val(sety_val),
    .mode_en(mode_en), .mode_on(mode_on), .mode_allon(mode_allon), .mode_inv(mode_inv),
    .mode_vflip(mode_vflip), .scan_req(scan_req), .scan_bank(scan_bank), .scan_col(scan_col),
    .pix_out(pix_out), .pix_valid(pix_valid), .drv_en(drv_en), .bias_en(bias_en),
    .vgen_en(vgen_en), .osc_en(osc_en)
  );

  // Behavioural reference model, advanced on every rising edge
  int  mem [NB*NC];
  int  mx, my, d1, d2;
  bit  m_on, m_all, m_inv, m_vf, v1, v2, en_exp;

  function automatic int shape(int d, bit on, bit all, bit inv);
    if (!on) return 0;
    if (all) return 255;
    if (inv) return (~d) & 255;
    return d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mx = 0; my = 0; v1 = 0; v2 = 0; d2 = 0;
      m_on = 0; m_all = 1; m_inv = 0; m_vf = 0; en_exp = 0;
    end else begin
      d2 = shape(d1, m_on, m_all, m_inv);
      v2 = v1;
      v1 = scan_req;
      d1 = mem[(m_vf ? (NB-1-int'(scan_bank)) : int'(scan_bank)) * NC + int'(scan_col)];
      if (wr_en) mem[my*NC + (mirror_x ? NC-1-mx : mx)] = int'(wr_data);
      if (setx_en && setx_val < NC) mx = setx_val;
      else if (wr_en) begin
        if (mx == NC-1) begin
          mx = 0;
          if (!(sety_en && sety_val < NB)) my = (my == NB-1) ? 0 : my + 1;
        end else mx = mx + 1;
      end
      if (sety_en && sety_val < NB) my = sety_val;
      if (mode_en) begin
        m_on = mode_on; m_all = mode_allon; m_inv = mode_inv; m_vf = mode_vflip;
        en_exp = !(!mode_on && mode_allon);
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ({drv_en, bias_en, vgen_en, osc_en} != {4{en_exp}}) begin
        errors++;
        $display("FAIL R9 enables actual %b expected %b", {drv_en, bias_en, vgen_en, osc_en}, {4{en_exp}});
      end
      checks++;
      if (pix_valid !== v2) begin
        errors++;
        $display("FAIL R7 pix_valid actual %b expected %b", pix_valid, v2);
      end
      if (v2) begin
        checks++;
        if (int'(pix_out) != d2) begin
          errors++;
          $display("FAIL R8 pix_out actual %0d expected %0d", pix_out, d2);
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmd_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic cmd_setx(input logic [6:0] v);
    @(negedge clk); setx_en = 1; setx_val = v;
    @(negedge clk); setx_en = 0;
  endtask
  task automatic cmd_sety(input logic [4:0] v);
    @(negedge clk); sety_en = 1; sety_val = v;
    @(negedge clk); sety_en = 0;
  endtask
  task automatic cmd_mode(input bit on, input bit all, input bit inv, input bit vf);
    @(negedge clk); mode_en = 1; mode_on = on; mode_allon = all; mode_inv = inv; mode_vflip = vf;
    @(negedge clk); mode_en = 0;
  endtask
  // Request on a falling edge; result is sampled after the second rising edge
  task automatic scan_check(input logic [4:0] b, input logic [6:0] c, input int exp, input string tag);
    @(negedge clk); scan_req = 1; scan_bank = b; scan_col = c;
    @(negedge clk); scan_req = 0;
    @(negedge clk);
    chk({tag, " valid"}, int'(pix_valid), 1);
    chk(tag, int'(pix_out), exp);
  endtask

  function automatic int fill_val(int i);
    return (i*7 + 3) % 256;
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 drv_en", int'(drv_en), 0);
    chk("R1 osc_en", int'(osc_en), 0);
    chk("R1 pix_valid", int'(pix_valid), 0);
    chk("R1 pix_out", int'(pix_out), 0);

    cmd_mode(1, 0, 0, 0);
    chk("R9 live enables", int'(drv_en & bias_en & vgen_en & osc_en), 1);

    // R2: fill whole RAM through auto-increment, then check wrap
    cmd_setx(0); cmd_sety(0);
    @(negedge clk); wr_en = 1;
    for (int i = 0; i < NB*NC; i++) begin
      wr_data = 8'(fill_val(i));
      @(negedge clk);
    end
    wr_en = 0;
    scan_check(0, 95, fill_val(95), "R2 end of bank0");
    scan_check(1, 0, fill_val(96), "R2 start of bank1");
    scan_check(16, 95, fill_val(NB*NC-1), "R2 last cell");
    cmd_write(8'hA5);
    scan_check(0, 0, 8'hA5, "R2 bank wrap to 0");

    // R3: column set and ignored out-of-range column
    cmd_setx(50); cmd_setx(120);
    cmd_write(8'h11);
    scan_check(0, 50, 8'h11, "R3 column set kept");
    scan_check(0, 1, fill_val(1), "R3 column 1 untouched");

    // R4: bank set and ignored out-of-range bank
    cmd_sety(5); cmd_sety(20); cmd_setx(10);
    cmd_write(8'h22);
    scan_check(5, 10, 8'h22, "R4 bank set kept");

    // R5: mirrored write position, existing data unchanged
    mirror_x = 1;
    cmd_setx(3); cmd_sety(2);
    cmd_write(8'h33);
    scan_check(2, 92, 8'h33, "R5 mirrored column");
    scan_check(2, 3, fill_val(2*NC+3), "R5 unmirrored column untouched");
    scan_check(0, 50, 8'h11, "R5 old data kept");
    mirror_x = 0;

    // R6: vertical flip on readout
    cmd_mode(1, 0, 0, 1);
    scan_check(14, 92, 8'h33, "R6 flipped bank");
    scan_check(16, 0, 8'hA5, "R6 flipped bank 16 to 0");
    cmd_mode(1, 0, 0, 0);

    // R8: display modes
    cmd_mode(1, 0, 1, 0);
    scan_check(2, 92, 8'hCC, "R8 inverse");
    cmd_mode(1, 1, 0, 0);
    scan_check(2, 92, 8'hFF, "R8 all on");
    cmd_mode(0, 0, 0, 0);
    scan_check(2, 92, 0, "R8 blank");
    chk("R9 blank keeps enables", int'(osc_en), 1);

    // R9 / R10: power-down, writes still land
    cmd_mode(0, 1, 0, 0);
    chk("R9 pd drv_en", int'(drv_en), 0);
    chk("R9 pd bias_en", int'(bias_en), 0);
    cmd_setx(7); cmd_sety(7);
    cmd_write(8'h77);
    scan_check(7, 7, 0, "R9 pd output dark");
    cmd_mode(1, 0, 0, 0);
    scan_check(7, 7, 8'h77, "R10 write in power-down");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule